// File: doc/BRIEF.md
# Audio Direction Control and Status Register

This block is the single control/status word for one direction (transmit or receive) of a serial audio port. Software writes it over a plain 32-bit register bus, made of a write strobe, write data and an always-valid read data word. The word holds a direction enable, a DMA enable for FIFO requests, one interrupt enable per status flag, a self-clearing FIFO pointer reset and a software reset. The serializer and the FIFO drive the status flags. Three of the flags are sticky and are set by one-cycle event pulses: word start, frame-sync error, and FIFO error (underrun when transmitting, overflow when receiving). The other two flags, FIFO warning and FIFO request, follow level inputs live.

The block drives an interrupt line, a DMA request and control strobes to the rest of the direction. Each interrupt enable sits a fixed distance below its flag in the same word, so one mask lines the two up. When the direction enable is cleared, the active indication stays high until the serializer reports the end of the current frame. Software can therefore poll for a clean stop, disabling the transmit side first and enabling it last.

Top module: `aud_dir_csr`

## Requirements
- R1: After reset the read word is 0 and irq, dma_req, fifo_ptr_rst, dir_soft_rst and dir_active are all 0.
- R2: A write stores bit 0 (DMA enable) and bits 12:8 (interrupt enables for flags 16..20, in flag order), and the read word returns them as written.
- R3: A pulse on evt_word_start, evt_sync_err or evt_fifo_err sets read bit 16, 17 or 18 respectively. The bit then stays set with no further pulse.
- R4: Writing 1 to bit 16, 17 or 18 clears that flag, and writing 0 leaves it unchanged. If an event pulse arrives in the same cycle as the clearing write, the flag stays set.
- R5: Read bits 19 (FIFO warning) and 20 (FIFO request) follow lvl_fifo_warn and lvl_fifo_req in the same cycle. Writing 1 to these bits has no effect.
- R6: irq is high exactly when some flag in bits 20:16 is set and the enable 8 positions below it is also set.
- R7: dma_req equals read bit 20 ANDed with the DMA enable in bit 0.
- R8: A write with bit 24 set makes fifo_ptr_rst high for exactly the one cycle after the write. Bit 24 always reads 0.
- R9: While software reset (bit 25) is 1, every other read bit is 0. Events, level inputs and writes to other bits are ignored, irq and dma_req stay 0, and dir_soft_rst is 1. Writing 0 to bit 25 releases the reset.
- R10: Writing 1 to bit 31 makes read bit 31 and dir_active 1 from the next cycle. After bit 31 is written 0 they stay 1 until a frame_end pulse. A frame_end pulse while the enable is set does nothing.
- R11: Clearing the direction enable leaves the sticky flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| evt_word_start | input | 1 | Pulse: serializer started a word |
| evt_sync_err | input | 1 | Pulse: frame-sync error |
| evt_fifo_err | input | 1 | Pulse: FIFO underrun/overflow |
| lvl_fifo_warn | input | 1 | Level: FIFO empty (tx) or full (rx) |
| lvl_fifo_req | input | 1 | Level: FIFO watermark reached |
| frame_end | input | 1 | Pulse: serializer finished a frame |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| fifo_ptr_rst | output | 1 | One-cycle FIFO pointer reset strobe |
| dir_soft_rst | output | 1 | Held reset for the direction logic |
| dir_active | output | 1 | Direction is running |

## Verification
The bench builds the block with its default layout: enables at bit 8, flags at bit 16, and a combinational interrupt output. With these values the live FIFO flags reach irq and dma_req in the same cycle, so a one-cycle slip in the mask path shows up at once. Directed sequences first cover each corner: a set and a clear landing in the same cycle, a disable waiting for the frame end, and writes made while the software reset holds. A long random phase then mixes writes, events, level changes and frame ends. It also raises the software reset now and then, which exercises its interaction with the enable tracker.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;

   localparam int unsigned CSR_W   = 32;
   localparam int unsigned N_FLAGS = 5;

   // order of the status flags; an interrupt enable shares this order
   typedef enum int unsigned {
      FL_WORD  = 0,
      FL_SYNC  = 1,
      FL_FIFO  = 2,
      FL_WARN  = 3,
      FL_REQ   = 4
   } flag_idx_e;

   // flags that latch event pulses and clear on a written one
   localparam logic [N_FLAGS-1:0] STICKY_MASK = 5'b00111;

   // fixed single-bit control fields
   localparam int unsigned BIT_DMA_EN   = 0;
   localparam int unsigned BIT_FIFO_RST = 24;
   localparam int unsigned BIT_SOFT_RST = 25;
   localparam int unsigned BIT_DIR_EN   = 31;

endpackage

// File: rtl/aud_flag_bank.sv
module aud_flag_bank
   import aud_csr_pkg::*;
#(
   parameter int unsigned        NF     = N_FLAGS,
   parameter logic [NF-1:0]      STICKY = STICKY_MASK
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          quiet,
   input  logic [NF-1:0] src_i,
   input  logic [NF-1:0] clr_i,
   output logic [NF-1:0] flag_o
);

   for (genvar i = 0; i < NF; i++) begin : g_flag
      if (STICKY[i]) begin : g_sticky
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_q <= 1'b0;
            else if (hold)      flag_q <= 1'b0;
            else if (src_i[i])  flag_q <= 1'b1;
            else if (clr_i[i])  flag_q <= 1'b0;
         end
         assign flag_o[i] = flag_q;

         // R4
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hold && src_i[i]) |=> flag_o[i]);

         // R3
         sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hold && flag_o[i] && !clr_i[i]) |=> flag_o[i]);
      end else begin : g_live
         logic clr_unused;
         assign clr_unused = clr_i[i];
         assign flag_o[i]  = src_i[i] & ~quiet;
      end
   end

endmodule

// File: rtl/aud_enable_track.sv
module aud_enable_track (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic wr,
   input  logic en_val,
   input  logic frame_end,
   output logic en_req,
   output logic active
);

   logic en_q, act_q, en_next;

   assign en_next = wr ? en_val : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         act_q <= 1'b0;
      end else if (hold) begin
         en_q  <= 1'b0;
         act_q <= 1'b0;
      end else begin
         en_q <= en_next;
         if (en_next)        act_q <= 1'b1;
         else if (frame_end) act_q <= 1'b0;
      end
   end

   assign en_req = en_q;
   assign active = act_q;

   // R10
   drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !frame_end && !hold) |=> act_q);

   // R10
   start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && en_val && !hold) |=> act_q);

endmodule

// File: rtl/aud_irq_out.sv
module aud_irq_out
   import aud_csr_pkg::*;
#(
   parameter int unsigned NF      = N_FLAGS,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic [NF-1:0] flags,
   input  logic [NF-1:0] ie,
   output logic          irq
);

   logic irq_comb;
   assign irq_comb = |(flags & ie);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    irq_q <= 1'b0;
         else if (hold) irq_q <= 1'b0;
         else           irq_q <= irq_comb;
      end
      assign irq = irq_q;
   end else begin : g_comb
      logic hold_unused;
      logic clk_unused;
      assign hold_unused = hold;
      assign clk_unused  = clk;
      assign irq = irq_comb;

      // R6
      irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ie == '0) |-> !irq);
   end

endmodule

// File: rtl/aud_dir_csr.sv
module aud_dir_csr
   import aud_csr_pkg::*;
#(
   parameter int unsigned IE_LSB   = 8,
   parameter int unsigned FLAG_LSB = 16,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [CSR_W-1:0] reg_wdata,
   output logic [CSR_W-1:0] reg_rdata,
   input  logic             evt_word_start,
   input  logic             evt_sync_err,
   input  logic             evt_fifo_err,
   input  logic             lvl_fifo_warn,
   input  logic             lvl_fifo_req,
   input  logic             frame_end,
   output logic             irq,
   output logic             dma_req,
   output logic             fifo_ptr_rst,
   output logic             dir_soft_rst,
   output logic             dir_active
);

   localparam int unsigned IE_TOP   = IE_LSB + N_FLAGS;
   localparam int unsigned FLAG_TOP = FLAG_LSB + N_FLAGS;

   if (IE_LSB <= BIT_DMA_EN || IE_TOP > FLAG_LSB) begin : g_bad_ie
      $error("interrupt enable field overlaps another field");
   end
   if (FLAG_TOP > BIT_FIFO_RST) begin : g_bad_flag
      $error("status flag field overlaps the reset bits");
   end

   logic               sw_rst_q, dma_en_q, fifo_rst_q;
   logic [N_FLAGS-1:0] ie_q;
   logic [N_FLAGS-1:0] flags, src, clr;
   logic               hold, en_req, active;
   logic               wdata_unused;

   assign wdata_unused = ^reg_wdata;

   // hold: reset is in force now or is being entered by this write
   assign hold = sw_rst_q | (reg_wr & reg_wdata[BIT_SOFT_RST]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_rst_q   <= 1'b0;
         dma_en_q   <= 1'b0;
         ie_q       <= '0;
         fifo_rst_q <= 1'b0;
      end else begin
         if (reg_wr) sw_rst_q <= reg_wdata[BIT_SOFT_RST];
         if (hold) begin
            dma_en_q   <= 1'b0;
            ie_q       <= '0;
            fifo_rst_q <= 1'b0;
         end else begin
            fifo_rst_q <= reg_wr & reg_wdata[BIT_FIFO_RST];
            if (reg_wr) begin
               dma_en_q <= reg_wdata[BIT_DMA_EN];
               ie_q     <= reg_wdata[IE_LSB +: N_FLAGS];
            end
         end
      end
   end

   always_comb begin
      src            = '0;
      src[FL_WORD]   = evt_word_start;
      src[FL_SYNC]   = evt_sync_err;
      src[FL_FIFO]   = evt_fifo_err;
      src[FL_WARN]   = lvl_fifo_warn;
      src[FL_REQ]    = lvl_fifo_req;
   end

   assign clr = reg_wr ? reg_wdata[FLAG_LSB +: N_FLAGS] : '0;

   aud_flag_bank #(.NF(N_FLAGS), .STICKY(STICKY_MASK)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .quiet  (sw_rst_q),
      .src_i  (src),
      .clr_i  (clr),
      .flag_o (flags)
   );

   aud_enable_track u_enable (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (hold),
      .wr        (reg_wr),
      .en_val    (reg_wdata[BIT_DIR_EN]),
      .frame_end (frame_end),
      .en_req    (en_req),
      .active    (active)
   );

   aud_irq_out #(.NF(N_FLAGS), .IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .flags (flags),
      .ie    (ie_q),
      .irq   (irq)
   );

   always_comb begin
      reg_rdata                         = '0;
      reg_rdata[BIT_DMA_EN]             = dma_en_q;
      reg_rdata[IE_LSB +: N_FLAGS]      = ie_q;
      reg_rdata[FLAG_LSB +: N_FLAGS]    = flags;
      reg_rdata[BIT_SOFT_RST]           = sw_rst_q;
      reg_rdata[BIT_DIR_EN]             = active;
   end

   assign dma_req      = flags[FL_REQ] & dma_en_q;
   assign fifo_ptr_rst = fifo_rst_q;
   assign dir_soft_rst = sw_rst_q;
   assign dir_active   = active;

   logic en_req_unused;
   assign en_req_unused = en_req;

   // R7
   dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_wdata[BIT_DMA_EN]) |=> !dma_req);

   // R8
   fifo_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_ptr_rst |-> $past(reg_wr && reg_wdata[BIT_FIFO_RST]));

   // R8
   fifo_rst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[BIT_FIFO_RST]);

   // R9
   soft_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_soft_rst |-> (!irq && !dma_req && !fifo_ptr_rst && !dir_active));

endmodule

// File: tb/tb_aud_dir_csr.sv
module tb_aud_dir_csr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  ev = '0;
   logic        lv_warn = 1'b0, lv_req = 1'b0, fend = 1'b0;
   logic        irq, dma_req, fifo_ptr_rst, dir_soft_rst, dir_active;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   aud_dir_csr dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .evt_word_start(ev[0]), .evt_sync_err(ev[1]),
      .evt_fifo_err(ev[2]), .lvl_fifo_warn(lv_warn), .lvl_fifo_req(lv_req),
      .frame_end(fend), .irq(irq), .dma_req(dma_req),
      .fifo_ptr_rst(fifo_ptr_rst), .dir_soft_rst(dir_soft_rst),
      .dir_active(dir_active)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic       m_dma = 0, m_sw = 0, m_fr = 0, m_en = 0, m_act = 0;
   logic [4:0] m_ie = '0;
   logic [2:0] m_fl = '0;

   always @(posedge clk) begin
      logic hold, new_en;
      if (!rst_n) begin
         m_dma = 0; m_sw = 0; m_fr = 0; m_en = 0; m_act = 0; m_ie = '0; m_fl = '0;
      end else begin
         hold = m_sw || (reg_wr && reg_wdata[25]);
         if (reg_wr) m_sw = reg_wdata[25];
         if (hold) begin
            m_dma = 0; m_fr = 0; m_en = 0; m_act = 0; m_ie = '0; m_fl = '0;
         end else begin
            m_fr = reg_wr && reg_wdata[24];
            for (int i = 0; i < 3; i++) begin
               if (ev[i]) m_fl[i] = 1;
               else if (reg_wr && reg_wdata[16+i]) m_fl[i] = 0;
            end
            new_en = reg_wr ? reg_wdata[31] : m_en;
            if (reg_wr) begin
               m_dma = reg_wdata[0];
               m_ie  = reg_wdata[12:8];
            end
            m_en = new_en;
            if (new_en) m_act = 1;
            else if (fend) m_act = 0;
         end
      end
   end

   function automatic logic [31:0] exp_word();
      logic [31:0] w = '0;
      w[0] = m_dma;
      w[12:8] = m_ie;
      w[18:16] = m_fl;
      w[19] = lv_warn & ~m_sw;
      w[20] = lv_req & ~m_sw;
      w[25] = m_sw;
      w[31] = m_act;
      return w;
   endfunction

   always @(negedge clk) begin
      logic [31:0] w;
      #2;
      w = exp_word();
      chk("R2 read word", reg_rdata, w);
      chk("R6 irq", {31'b0, irq}, {31'b0, |(w[20:16] & w[12:8])});
      chk("R7 dma_req", {31'b0, dma_req}, {31'b0, w[20] & w[0]});
      chk("R8 fifo_ptr_rst", {31'b0, fifo_ptr_rst}, {31'b0, m_fr});
      chk("R9 dir_soft_rst", {31'b0, dir_soft_rst}, {31'b0, m_sw});
      chk("R10 dir_active", {31'b0, dir_active}, {31'b0, m_act});
   end

   task automatic step(input logic w, input logic [31:0] d, input logic [2:0] e, input logic f);
      @(negedge clk);
      reg_wr = w; reg_wdata = d; ev = e; fend = f;
      @(negedge clk);
      reg_wr = 0; ev = '0; fend = 0;
      #1;
   endtask

   task automatic wr(input logic [31:0] d);
      step(1'b1, d, 3'b000, 1'b0);
   endtask

   task automatic pulse(input logic [2:0] e, input logic f);
      step(1'b0, 32'h0, e, f);
   endtask

   localparam logic [31:0] BASE = 32'h0000_1F01;

   initial begin
      #5000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1;
      // R1
      chk("R1 rdata", reg_rdata, 32'h0);
      chk("R1 outs", {27'b0, irq, dma_req, fifo_ptr_rst, dir_soft_rst, dir_active}, 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      pulse(3'b000, 1'b0);
      chk("R1 after release", reg_rdata, 32'h0);

      wr(BASE);
      chk("R2 readback", reg_rdata, BASE);
      pulse(3'b001, 1'b0);
      chk("R3 word start set", reg_rdata, 32'h0001_1F01);
      chk("R6 irq on flag", {31'b0, irq}, 32'h1);
      pulse(3'b000, 1'b0);
      chk("R3 flag held", reg_rdata, 32'h0001_1F01);
      wr(BASE | (32'h1 << 17));
      chk("R4 zero leaves flag", reg_rdata, 32'h0001_1F01);
      wr(BASE | (32'h1 << 16));
      chk("R4 w1c clears", reg_rdata, BASE);
      chk("R6 irq dropped", {31'b0, irq}, 32'h0);
      pulse(3'b010, 1'b0);
      step(1'b1, BASE | (32'h1 << 17), 3'b010, 1'b0);
      chk("R4 set wins", reg_rdata, 32'h0002_1F01);
      wr(BASE | (32'h1 << 17));
      chk("R4 cleared", reg_rdata, BASE);

      lv_req = 1; #1;
      chk("R5 live req", reg_rdata, 32'h0010_1F01);
      chk("R7 dma on", {31'b0, dma_req}, 32'h1);
      wr(BASE | (32'h3 << 19));
      chk("R5 w1 no effect", reg_rdata, 32'h0010_1F01);
      wr(32'h0000_1F00);
      chk("R7 dma gated", {31'b0, dma_req}, 32'h0);
      wr(32'h0000_0F00);
      chk("R6 masked", {31'b0, irq}, 32'h0);
      lv_req = 0; lv_warn = 1; #1;
      chk("R5 live warn", reg_rdata, 32'h0008_0F00);
      chk("R6 warn irq", {31'b0, irq}, 32'h1);
      lv_warn = 0;

      wr(32'h0000_0400);
      pulse(3'b100, 1'b0);
      chk("R6 fifo err", reg_rdata, 32'h0004_0400);
      chk("R6 fifo irq", {31'b0, irq}, 32'h1);
      wr(32'h0004_0400);

      wr(32'h0100_0000);
      chk("R8 strobe", {31'b0, fifo_ptr_rst}, 32'h1);
      chk("R8 reads 0", reg_rdata, 32'h0);
      pulse(3'b000, 1'b0);
      chk("R8 one cycle", {31'b0, fifo_ptr_rst}, 32'h0);

      wr(32'h8000_0000);
      chk("R10 active", {31'b0, dir_active}, 32'h1);
      pulse(3'b000, 1'b1);
      chk("R10 frame end while enabled", reg_rdata, 32'h8000_0000);
      pulse(3'b001, 1'b0);
      wr(32'h0);
      chk("R11 drain keeps flag", reg_rdata, 32'h8001_0000);
      repeat (3) pulse(3'b000, 1'b0);
      chk("R10 still draining", {31'b0, dir_active}, 32'h1);
      pulse(3'b000, 1'b1);
      chk("R10 stopped", {31'b0, dir_active}, 32'h0);
      chk("R11 flag kept", reg_rdata, 32'h0001_0000);

      wr(BASE | 32'h8000_0000);
      pulse(3'b111, 1'b0);
      wr(BASE | (32'h1 << 25));
      chk("R9 soft reset", reg_rdata, 32'h0200_0000);
      chk("R9 outs", {29'b0, irq, dir_soft_rst, dir_active}, 32'h2);
      pulse(3'b111, 1'b0);
      lv_req = 1; #1;
      chk("R9 events ignored", reg_rdata, 32'h0200_0000);
      chk("R9 dma quiet", {31'b0, dma_req}, 32'h0);
      wr(BASE | 32'h8200_0000);
      chk("R9 writes ignored", reg_rdata, 32'h0200_0000);
      wr(32'h0);
      chk("R9 released", reg_rdata, 32'h0010_0000);
      lv_req = 0;

      for (int k = 0; k < 600; k++) begin
         logic [31:0] d;
         d = $urandom;
         if ($urandom_range(0, 15) != 0) d[25] = 1'b0;
         lv_warn = $urandom_range(0, 1);
         lv_req  = $urandom_range(0, 1);
         step($urandom_range(0, 2) == 0, d,
              ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000,
              $urandom_range(0, 5) == 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule